// File: doc/BRIEF.md
# Guarded Stop-Mode Entry Sequencer

This block owns a three-bit control register whose top field can request a low-power stop state. Software cannot set that request with a single write. It must write the stop field as 1, then 0, then 1, in three consecutive writes to this register, with no write to any other register in between. When the third write lands, the block checks the wake-up subsystem. Entry is refused if any enabled wake-up line is already pending, if no wake-up line is enabled, or if the wake-up-mode field is clear. A high NMI level also blocks entry, but it leaves the stop field reading 1.

After an accepted pattern, the block waits a programmable number of cycles. Any register write in that window cancels the entry. It then raises a stop request towards the clock controller. When the controller acknowledges, the block reports that the device is stopped. It leaves the stopped state in one of two ways. A pending event on an enabled wake-up line clears the stop field. A rising NMI edge leaves the stop field at 1 and sets an exited-by-NMI flag. An active-low external pin can also force the stop request, whatever the register holds.

Top module: `stop_entry_guard`

## Requirements
- R1: After reset the control register reads 000, and stop_req, stopped and exited_stop are all 0.
- R2: Register layout: bit 2 is the stop field, bit 1 is the interrupt-source select and bit 0 is the wake-up-mode field. Every write to this register stores bits 1 and 0 directly, and a read returns all three bits.
- R3: Writing 1 to the stop field reads back as 1, and a following write of 0 reads back as 0. When the 1, 0, 1 pattern completes with its conditions met, the field reads 1. stop_req then rises exactly ENTRY_LAT cycles after the clock edge that took the third write.
- R4: A write to any other register while the pattern is in progress aborts it and clears the stop field. A later 0-then-1 does not complete the pattern; it must restart from a write of 1.
- R5: The pattern is refused when any line has both its pending bit and its mask bit set, when all mask bits are 0, or when the wake-up-mode value written by the third write is 0. A mask bit of 1 means the line is enabled. On refusal the stop field reads 0 and stop_req stays low.
- R6: Any register write during the entry delay, or after stop_req rises but before stopped is set, cancels the entry. The stop field reads 0 and stop_req falls on the next cycle.
- R7: While stopped, any line with both its pending bit and its mask bit set clears stopped, the stop field and stop_req at the next clock edge.
- R8: While stopped, a rising edge on nmi clears stopped at the next clock edge. The stop field stays 1 and exited_stop becomes 1.
- R9: If nmi is high when the third write lands, the stop field reads 1, stop_req stays low and exited_stop stays 0.
- R10: While ext_stop_n is 0, stop_req is 1 whatever the register holds. With stop_ack high, stopped then sets.
- R11: stopped sets on the clock edge after a cycle in which stop_req and stop_ack are both 1.
- R12: exited_stop is cleared by the next write of 1 that starts a pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for this control register |
| ctl_wdata | input | 3 | Write data: bit 2 stop, bit 1 source select, bit 0 wake-up mode |
| other_wr | input | 1 | Strobe for a write to any other register (CPU, interrupt or DMA) |
| nmi | input | 1 | Non-maskable interrupt pin level |
| ext_stop_n | input | 1 | External stop pin, active low |
| wk_pend | input | LINES | Wake-up line pending bits |
| wk_mask | input | LINES | Wake-up line enables, 1 = enabled |
| stop_ack | input | 1 | Clock controller acknowledge of the stop request |
| ctl_rdata | output | 3 | Control register read value |
| stop_req | output | 1 | Stop request to the clock controller |
| stopped | output | 1 | Device is in stop state |
| exited_stop | output | 1 | Last stop exit was caused by NMI |

## Verification
A wrong pattern state shows at ctl_rdata bit 2 on the very next read after the write that exposes it. It can also show as stop_req rising or not rising exactly ENTRY_LAT cycles after the third write. An off-by-one in the entry delay counter moves that stop_req edge by one cycle, and the bench checks each cycle of the window. A wrong exit decision shows in the single cycle after the wake event, in the pair of stop field and exited_stop values.

// File: rtl/stop_guard_pkg.sv
package stop_guard_pkg;
    localparam int CTL_W     = 3;
    localparam int BIT_STOP  = 2;
    localparam int BIT_SRC   = 1;
    localparam int BIT_WMODE = 0;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ONE,
        SQ_ONE_ZERO,
        SQ_WAIT,
        SQ_ARMED
    } seq_state_e;
endpackage

// File: rtl/stop_qualify.sv
module stop_qualify #(
    parameter int LINES = 16
) (
    input  logic [LINES-1:0] wk_pend,
    input  logic [LINES-1:0] wk_mask,
    input  logic             wmode_new,
    output logic             cond_ok
);
    logic any_live_pend;
    logic any_enabled;

    always_comb begin
        any_live_pend = |(wk_pend & wk_mask);
        any_enabled   = |wk_mask;
        cond_ok       = wmode_new && !any_live_pend && any_enabled;
    end
endmodule

// File: rtl/stop_wake.sv
module stop_wake #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi,
    input  logic [LINES-1:0] wk_pend,
    input  logic [LINES-1:0] wk_mask,
    input  logic             stop_req,
    input  logic             stop_ack,
    input  logic             flag_clr,
    output logic             stopped,
    output logic             line_wake,
    output logic             nmi_wake,
    output logic             exited
);
    typedef struct packed {
        logic nmi_prev;
        logic stopped;
        logic exited;
    } wake_regs_t;

    wake_regs_t r_q, r_d;

    always_comb begin
        line_wake = r_q.stopped && (|(wk_pend & wk_mask));
        nmi_wake  = r_q.stopped && nmi && !r_q.nmi_prev;
        r_d          = r_q;
        r_d.nmi_prev = nmi;
        if (r_q.stopped) begin
            r_d.stopped = !(line_wake || nmi_wake);
        end else begin
            r_d.stopped = stop_req && stop_ack;
        end
        if (flag_clr) begin
            r_d.exited = 1'b0;
        end else if (nmi_wake && !line_wake) begin
            r_d.exited = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stopped = r_q.stopped;
    assign exited  = r_q.exited;

    // R7: an enabled pending line while stopped ends the stopped state
    a_r7_line_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && (|(wk_pend & wk_mask))) |=> !stopped);

    // R8: an NMI rising edge while stopped sets the exit flag
    a_r8_nmi_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && $rose(nmi) && !(|(wk_pend & wk_mask))) |=> (exited && !stopped));

    // R11: stopped only rises after a granted request
    a_r11_stop_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> $past(stop_req && stop_ack));
endmodule

// File: rtl/stop_pattern.sv
module stop_pattern
    import stop_guard_pkg::*;
#(
    parameter int ENTRY_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             other_wr,
    input  logic             nmi,
    input  logic             cond_ok,
    input  logic             stopped,
    input  logic             line_wake,
    input  logic             nmi_wake,
    output logic [CTL_W-1:0] ctl_bits,
    output logic             armed,
    output logic             flag_clr
);
    localparam int CW = $clog2(ENTRY_LAT + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(ENTRY_LAT - 1);

    typedef struct packed {
        seq_state_e      st;
        logic [CW-1:0]   cnt;
        logic            stop;
        logic            src;
        logic            wmode;
    } seq_regs_t;

    seq_regs_t s_q, s_d;
    logic      any_wr;
    logic      wr_one;

    always_comb begin
        s_d      = s_q;
        flag_clr = 1'b0;
        any_wr   = ctl_wr || other_wr;
        wr_one   = ctl_wdata[BIT_STOP];
        if (ctl_wr) begin
            s_d.src   = ctl_wdata[BIT_SRC];
            s_d.wmode = ctl_wdata[BIT_WMODE];
        end
        unique case (s_q.st)
            SQ_IDLE: begin
                if (ctl_wr && !other_wr) begin
                    s_d.stop = wr_one;
                    if (wr_one) begin
                        s_d.st   = SQ_ONE;
                        flag_clr = 1'b1;
                    end
                end
            end
            SQ_ONE: begin
                if (other_wr) begin
                    s_d.st   = SQ_IDLE;
                    s_d.stop = 1'b0;
                end else if (ctl_wr) begin
                    if (wr_one) begin
                        flag_clr = 1'b1;
                    end else begin
                        s_d.st   = SQ_ONE_ZERO;
                        s_d.stop = 1'b0;
                    end
                end
            end
            SQ_ONE_ZERO: begin
                if (other_wr) begin
                    s_d.st   = SQ_IDLE;
                    s_d.stop = 1'b0;
                end else if (ctl_wr) begin
                    s_d.st   = SQ_IDLE;
                    s_d.stop = 1'b0;
                    if (wr_one && nmi) begin
                        s_d.stop = 1'b1;
                    end else if (wr_one && cond_ok) begin
                        s_d.stop = 1'b1;
                        s_d.st   = SQ_WAIT;
                        s_d.cnt  = CNT_LOAD;
                    end
                end
            end
            SQ_WAIT: begin
                if (any_wr) begin
                    s_d.st   = SQ_IDLE;
                    s_d.stop = 1'b0;
                end else if (s_q.cnt == '0) begin
                    s_d.st = SQ_ARMED;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SQ_ARMED: begin
                if (stopped) begin
                    if (line_wake) begin
                        s_d.st   = SQ_IDLE;
                        s_d.stop = 1'b0;
                    end else if (nmi_wake) begin
                        s_d.st = SQ_IDLE;
                    end
                end else if (any_wr) begin
                    s_d.st   = SQ_IDLE;
                    s_d.stop = 1'b0;
                end
            end
            default: begin
                s_d.st   = SQ_IDLE;
                s_d.stop = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, cnt: '0, stop: 1'b0, src: 1'b0, wmode: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctl_bits            = '0;
        ctl_bits[BIT_STOP]  = s_q.stop;
        ctl_bits[BIT_SRC]   = s_q.src;
        ctl_bits[BIT_WMODE] = s_q.wmode;
        armed               = (s_q.st == SQ_ARMED);
    end

    // R3: a lone write of 1 from idle makes the stop field read 1
    a_r3_first_write_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_IDLE && ctl_wr && !other_wr && ctl_wdata[BIT_STOP]) |=> ctl_bits[BIT_STOP]);

    // R4: a foreign write mid-pattern aborts it
    a_r4_foreign_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == SQ_ONE || s_q.st == SQ_ONE_ZERO) && other_wr)
            |=> (s_q.st == SQ_IDLE && !ctl_bits[BIT_STOP]));

    // R6: any write in the entry window cancels
    a_r6_window_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == SQ_WAIT || (s_q.st == SQ_ARMED && !stopped)) && (ctl_wr || other_wr))
            |=> (!armed && !ctl_bits[BIT_STOP]));

    // R9: NMI high at completion keeps the field at 1 without arming
    a_r9_nmi_high_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_ONE_ZERO && ctl_wr && !other_wr && ctl_wdata[BIT_STOP] && nmi)
            |=> (ctl_bits[BIT_STOP] && s_q.st == SQ_IDLE));
endmodule

// File: rtl/stop_entry_guard.sv
module stop_entry_guard
    import stop_guard_pkg::*;
#(
    parameter int LINES     = 16,
    parameter int ENTRY_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             other_wr,
    input  logic             nmi,
    input  logic             ext_stop_n,
    input  logic [LINES-1:0] wk_pend,
    input  logic [LINES-1:0] wk_mask,
    input  logic             stop_ack,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             stop_req,
    output logic             stopped,
    output logic             exited_stop
);
    logic cond_ok;
    logic armed;
    logic flag_clr;
    logic line_wake;
    logic nmi_wake;

    stop_qualify #(.LINES(LINES)) qual_i (
        .wk_pend   (wk_pend),
        .wk_mask   (wk_mask),
        .wmode_new (ctl_wdata[BIT_WMODE]),
        .cond_ok   (cond_ok)
    );

    stop_pattern #(.ENTRY_LAT(ENTRY_LAT)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .other_wr  (other_wr),
        .nmi       (nmi),
        .cond_ok   (cond_ok),
        .stopped   (stopped),
        .line_wake (line_wake),
        .nmi_wake  (nmi_wake),
        .ctl_bits  (ctl_rdata),
        .armed     (armed),
        .flag_clr  (flag_clr)
    );

    assign stop_req = armed || !ext_stop_n;

    stop_wake #(.LINES(LINES)) wake_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi       (nmi),
        .wk_pend   (wk_pend),
        .wk_mask   (wk_mask),
        .stop_req  (stop_req),
        .stop_ack  (stop_ack),
        .flag_clr  (flag_clr),
        .stopped   (stopped),
        .line_wake (line_wake),
        .nmi_wake  (nmi_wake),
        .exited    (exited_stop)
    );

    // R10: the external pin with a grant drives the device into stop
    a_r10_ext_pin_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_stop_n && stop_ack && !stopped) |=> stopped);
endmodule

// File: tb/stop_entry_guard_tb_top.sv
module stop_entry_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 16;
    localparam int LAT        = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [2:0]       ctl_wdata = '0;
    logic             other_wr = 1'b0;
    logic             nmi = 1'b0;
    logic             ext_stop_n = 1'b1;
    logic [LINES-1:0] wk_pend = '0;
    logic [LINES-1:0] wk_mask = 16'h0001;
    logic             stop_ack = 1'b1;
    logic [2:0]       ctl_rdata;
    logic             stop_req;
    logic             stopped;
    logic             exited_stop;

    int n_chk  = 0;
    int n_fail = 0;

    // bench reference for the pattern sequencer (no stop acknowledge)
    int m_st  = 0;
    int m_cnt = 0;
    int m_bit = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stop_entry_guard #(.LINES(LINES), .ENTRY_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .other_wr(other_wr), .nmi(nmi), .ext_stop_n(ext_stop_n),
        .wk_pend(wk_pend), .wk_mask(wk_mask), .stop_ack(stop_ack),
        .ctl_rdata(ctl_rdata), .stop_req(stop_req), .stopped(stopped),
        .exited_stop(exited_stop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] d);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic owr();
        other_wr = 1'b1;
        tick();
        other_wr = 1'b0;
    endtask

    task automatic pattern();
        wr(3'b101);
        wr(3'b001);
        wr(3'b101);
    endtask

    function automatic void model_step(input bit c, input bit d2, input bit o);
        case (m_st)
            0: if (c && !o) begin m_bit = d2; if (d2) m_st = 1; end
            1: if (o) begin m_st = 0; m_bit = 0; end
               else if (c && !d2) begin m_st = 2; m_bit = 0; end
            2: if (o) begin m_st = 0; m_bit = 0; end
               else if (c) begin
                   if (d2) begin m_st = 3; m_cnt = LAT - 1; m_bit = 1; end
                   else begin m_st = 0; m_bit = 0; end
               end
            3: if (c || o) begin m_st = 0; m_bit = 0; end
               else if (m_cnt == 0) m_st = 4;
               else m_cnt--;
            default: if (c || o) begin m_st = 0; m_bit = 0; end
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        // R1 reset state
        check("R1 rdata", 32'(ctl_rdata), 32'h0);
        check("R1 req", 32'(stop_req), 32'h0);
        check("R1 stopped/exited", 32'({stopped, exited_stop}), 32'h0);
        rst_n = 1'b1;
        tick();

        // R2 direct fields
        wr(3'b011);
        check("R2 fields", 32'(ctl_rdata), 32'h3);
        wr(3'b001);
        check("R2 fields rewrite", 32'(ctl_rdata), 32'h1);

        // R3 pattern and latency, R11 stopped after grant
        wr(3'b101);
        check("R3 first one", 32'(ctl_rdata[2]), 32'h1);
        wr(3'b001);
        check("R3 zero clears", 32'(ctl_rdata[2]), 32'h0);
        wr(3'b101);
        check("R3 completed", 32'(ctl_rdata[2]), 32'h1);
        for (int i = 1; i < LAT; i++) begin
            check("R3 no early req", 32'(stop_req), 32'h0);
            tick();
        end
        check("R3 no early req", 32'(stop_req), 32'h0);
        tick();
        check("R3 req at latency", 32'(stop_req), 32'h1);
        check("R11 not yet stopped", 32'(stopped), 32'h0);
        tick();
        check("R11 stopped", 32'(stopped), 32'h1);

        // R7 line wake
        wk_pend = 16'h0001;
        tick();
        check("R7 stopped cleared", 32'(stopped), 32'h0);
        check("R7 stop field cleared", 32'(ctl_rdata[2]), 32'h0);
        check("R7 req low", 32'(stop_req), 32'h0);
        wk_pend = '0;

        // R8 NMI wake
        pattern();
        repeat (LAT + 1) tick();
        check("R8 stopped before nmi", 32'(stopped), 32'h1);
        nmi = 1'b1;
        tick();
        check("R8 stopped cleared", 32'(stopped), 32'h0);
        check("R8 stop field kept", 32'(ctl_rdata[2]), 32'h1);
        check("R8 exited set", 32'(exited_stop), 32'h1);
        nmi = 1'b0;
        tick();

        // R12 flag clear, R4 abort
        wr(3'b101);
        check("R12 exited cleared", 32'(exited_stop), 32'h0);
        owr();
        check("R4 abort clears", 32'(ctl_rdata[2]), 32'h0);
        wr(3'b001);
        wr(3'b101);
        repeat (LAT + 2) tick();
        check("R4 no entry without restart", 32'(stop_req), 32'h0);
        wr(3'b001);
        owr();
        check("R4 abort after zero", 32'(ctl_rdata[2]), 32'h0);

        // R9 NMI high at completion
        nmi = 1'b1;
        pattern();
        check("R9 field reads one", 32'(ctl_rdata[2]), 32'h1);
        repeat (LAT + 2) tick();
        check("R9 no req", 32'(stop_req), 32'h0);
        check("R9 exited zero", 32'(exited_stop), 32'h0);
        nmi = 1'b0;
        wr(3'b001);

        // R5 refused entries
        wk_pend = 16'h0001;
        pattern();
        check("R5 live pending", 32'(ctl_rdata[2]), 32'h0);
        repeat (LAT + 1) tick();
        check("R5 live pending req", 32'(stop_req), 32'h0);
        wk_pend = 16'h0002;
        wk_mask = 16'h0000;
        pattern();
        check("R5 all masked", 32'(ctl_rdata[2]), 32'h0);
        wk_mask = 16'h0001;
        wr(3'b100); wr(3'b000); wr(3'b100);
        check("R5 wake mode off", 32'(ctl_rdata[2]), 32'h0);
        repeat (LAT + 1) tick();
        check("R5 wake mode off req", 32'(stop_req), 32'h0);

        // R6 cancellation in the window and before grant
        stop_ack = 1'b0;
        pattern();
        tick();
        owr();
        check("R6 cancel in delay", 32'(ctl_rdata[2]), 32'h0);
        repeat (LAT + 1) tick();
        check("R6 no req after cancel", 32'(stop_req), 32'h0);
        pattern();
        repeat (LAT) tick();
        check("R6 armed", 32'(stop_req), 32'h1);
        wr(3'b001);
        check("R6 cancel before grant", 32'(stop_req), 32'h0);
        check("R6 field cleared", 32'(ctl_rdata[2]), 32'h0);

        // R10 external pin
        ext_stop_n = 1'b0;
        #1;
        check("R10 pin forces req", 32'(stop_req), 32'h1);
        stop_ack = 1'b1;
        tick();
        check("R10 stopped by pin", 32'(stopped), 32'h1);
        ext_stop_n = 1'b1;
        wk_pend = 16'h0001;
        tick();
        check("R7 wake from pin stop", 32'(stopped), 32'h0);
        wk_pend = '0;
        stop_ack = 1'b0;
        wr(3'b001);

        // R3/R4/R6 random write streams against the bench reference
        m_st = 0; m_bit = 0; m_cnt = 0;
        for (int i = 0; i < 1500; i++) begin
            int op;
            bit c, d2, o;
            op = int'($urandom % 8);
            c  = (op >= 3 && op <= 6);
            d2 = (op == 3 || op == 4);
            o  = (op == 7);
            ctl_wr    = c;
            ctl_wdata = {d2, 2'b01};
            other_wr  = o;
            tick();
            model_step(c, d2, o);
            ctl_wr   = 1'b0;
            other_wr = 1'b0;
            check("R3 random stop field", 32'(ctl_rdata[2]), 32'(m_bit));
            check("R6 random req", 32'(stop_req), 32'(m_st == 4));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule